// File: doc/BRIEF.md
# Output Compare Channel

This block is one output compare channel. It watches the count of a free-running timer, which lives outside the block. It drives a single output pin according to a 3-bit mode field. The channel holds two compare registers, a primary one and a secondary one. Comparing these against the timer count produces the following waveforms:

- single edges (one-shot in either polarity),
- toggles,
- a delayed single pulse,
- a pulse that repeats every timer period,
- pulse-width modulation, with or without a fault shutdown.

When the channel is disabled, the pin simply shows a general-purpose output value.

Each mode sets its own pin level on entry and its own rule for raising the interrupt pulse. The channel treats the mode as entered in any cycle where the mode input differs from its value in the previous cycle. For the duration of that cycle's update, the entry level takes priority over any compare activity.

In the PWM modes, the secondary value acts as the duty cycle for the next period. It is copied into the primary register on every period-match strobe, so software can change the duty cycle without a glitch. The timer wraps to zero after each period-match strobe, so the waveform repeats.

Top module: `oc_unit`

## Requirements
- R1: After synchronous reset, both compare registers hold 0, the internal pin level is 0 and `irq` is 0. The mode history reads as disabled.
- R2: With `mode` = 3'b000, `pin_out` equals `gpio_val` in the same cycle and `irq` stays 0.
- R3: Mode 3'b001 sets the pin to 0 on entry. The first cycle in which `tmr` equals the primary value raises the pin to 1 and pulses `irq` with the rising edge. After that the pin does not change until the mode is rewritten.
- R4: Mode 3'b010 sets the pin to 1 on entry. The first primary match drops the pin to 0 and pulses `irq` with that falling edge. After that the pin does not change.
- R5: Mode 3'b011 keeps the current pin level on entry. It inverts the pin on every primary match and pulses `irq` on every such change, rising or falling.
- R6: Mode 3'b100 sets the pin to 0 on entry. A primary match while low raises the pin, and a secondary match while high lowers it, with an `irq` pulse on that falling edge. This happens only once per entry.
- R7: Mode 3'b101 behaves like R6 but repeats in every timer period. `irq` pulses on each falling edge.
- R8: On entry to mode 3'b110 or 3'b111, the pin is 1 if the primary value is non-zero, and 0 otherwise.
- R9: In modes 3'b110 and 3'b111, a `per_match` cycle copies the secondary value into the primary register and sets the pin to (secondary != 0). Otherwise a primary match clears the pin. Mode 3'b110 never pulses `irq`.
- R10: In mode 3'b111, `fault_n` low forces the pin to 0 and keeps it there until the mode changes. `irq` pulses on each high-to-low transition of `fault_n`.
- R11: The pin level and `irq` are registered. An event seen on the inputs in cycle t shows at the outputs in cycle t+1. A mode entry takes priority over compare events in its cycle.
- R12: `pri_we`/`sec_we` load their data on the clock edge. In the PWM modes, a `per_match` copy takes priority over a simultaneous `pri_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr | input | CW | Timer count |
| per_match | input | 1 | Timer period-match strobe (timer wraps to 0 next cycle) |
| mode | input | 3 | Mode field |
| pri_we | input | 1 | Primary compare register write enable |
| pri_wdata | input | CW | Primary compare write data |
| sec_we | input | 1 | Secondary compare register write enable |
| sec_wdata | input | CW | Secondary compare write data |
| gpio_val | input | 1 | Pin value while disabled |
| fault_n | input | 1 | Active-low fault input |
| pin_out | output | 1 | Pin drive |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with an 8-bit compare width and drives a timer that wraps every 21 counts. With these values, primary and secondary matches, period strobes and several full periods of every mode fit into a few hundred cycles. A zero primary value and zero secondary writes reach the empty-duty corner of PWM. A short fault pulse in the middle of a PWM run, followed by a mode rewrite, covers the latch and its release.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OCM_OFF       = 3'd0,
        OCM_SHOT_RISE = 3'd1,
        OCM_SHOT_FALL = 3'd2,
        OCM_TOGGLE    = 3'd3,
        OCM_DELAY     = 3'd4,
        OCM_PULSE     = 3'd5,
        OCM_PWM       = 3'd6,
        OCM_PWM_FLT   = 3'd7
    } ocm_e;

    // compare events seen in the current cycle
    typedef struct packed {
        logic hit_pri;
        logic hit_sec;
        logic period;
    } oc_evt_t;

    function automatic logic is_pwm(ocm_e m);
        return (m == OCM_PWM) || (m == OCM_PWM_FLT);
    endfunction

    // pin level loaded in the cycle a mode is entered
    function automatic logic entry_level(ocm_e m, logic cur, logic duty_nz);
        case (m)
            OCM_SHOT_FALL:        return 1'b1;
            OCM_OFF, OCM_TOGGLE:  return cur;
            OCM_PWM, OCM_PWM_FLT: return duty_nz;
            default:              return 1'b0;
        endcase
    endfunction

    // which pin transitions raise an interrupt in a given mode
    function automatic logic edge_irq(ocm_e m, logic old_lvl, logic new_lvl);
        case (m)
            OCM_SHOT_RISE:                      return !old_lvl && new_lvl;
            OCM_SHOT_FALL, OCM_DELAY, OCM_PULSE: return old_lvl && !new_lvl;
            OCM_TOGGLE:                         return old_lvl != new_lvl;
            default:                            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/oc_cmp_regs.sv
module oc_cmp_regs
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ocm_e          mode,
    input  logic [CW-1:0] tmr,
    input  logic          per_match,
    input  logic          pri_we,
    input  logic [CW-1:0] pri_wdata,
    input  logic          sec_we,
    input  logic [CW-1:0] sec_wdata,
    output logic [CW-1:0] pri_q,
    output logic [CW-1:0] sec_q,
    output oc_evt_t       evt
);

    logic reload;
    assign reload = is_pwm(mode) && per_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q <= '0;
            sec_q <= '0;
        end else begin
            if (reload)      pri_q <= sec_q;
            else if (pri_we) pri_q <= pri_wdata;
            if (sec_we)      sec_q <= sec_wdata;
        end
    end

    always_comb begin
        evt.hit_pri = (tmr == pri_q);
        evt.hit_sec = (tmr == sec_q);
        evt.period  = per_match;
    end

    assert_pwm_reload_R9: assert property (@(posedge clk) disable iff (rst)
        (is_pwm(mode) && per_match) |=> (pri_q == $past(sec_q)));

    assert_pri_write_R12: assert property (@(posedge clk) disable iff (rst)
        (pri_we && !(is_pwm(mode) && per_match)) |=> (pri_q == $past(pri_wdata)));

    assert_sec_write_R12: assert property (@(posedge clk) disable iff (rst)
        sec_we |=> (sec_q == $past(sec_wdata)));

endmodule

// File: rtl/oc_wave.sv
module oc_wave
    import oc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ocm_e    mode,
    input  oc_evt_t evt,
    input  logic    duty_nz,
    input  logic    sec_nz,
    input  logic    fault_n,
    output logic    pin_q,
    output logic    pin_d,
    output logic    entry,
    output logic    fault_fall
);

    ocm_e mode_q;
    logic done_q, done_d;
    logic flt_q, flt_d;
    logic fprev_q;

    assign entry      = (mode != mode_q);
    assign fault_fall = fprev_q && !fault_n;

    always_comb begin
        pin_d  = pin_q;
        done_d = done_q;
        flt_d  = flt_q;
        if (entry) begin
            done_d = 1'b0;
            flt_d  = 1'b0;
            pin_d  = entry_level(mode, pin_q, duty_nz);
        end else begin
            case (mode)
                OCM_SHOT_RISE, OCM_SHOT_FALL: begin
                    if (!done_q && evt.hit_pri) begin
                        pin_d  = !pin_q;
                        done_d = 1'b1;
                    end
                end
                OCM_TOGGLE: begin
                    if (evt.hit_pri) pin_d = !pin_q;
                end
                OCM_DELAY, OCM_PULSE: begin
                    if (pin_q && evt.hit_sec) begin
                        pin_d  = 1'b0;
                        done_d = (mode == OCM_DELAY);
                    end else if (!pin_q && !done_q && evt.hit_pri) begin
                        pin_d = 1'b1;
                    end
                end
                OCM_PWM, OCM_PWM_FLT: begin
                    if (mode == OCM_PWM_FLT && (flt_q || !fault_n)) begin
                        pin_d = 1'b0;
                        flt_d = 1'b1;
                    end else if (evt.period) begin
                        pin_d = sec_nz;
                    end else if (evt.hit_pri) begin
                        pin_d = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= OCM_OFF;
            pin_q   <= 1'b0;
            done_q  <= 1'b0;
            flt_q   <= 1'b0;
            fprev_q <= 1'b1;
        end else begin
            mode_q  <= mode;
            pin_q   <= pin_d;
            done_q  <= done_d;
            flt_q   <= flt_d;
            fprev_q <= fault_n;
        end
    end

    assert_shot_once_R3: assert property (@(posedge clk) disable iff (rst)
        ((mode == OCM_SHOT_RISE || mode == OCM_SHOT_FALL) && done_q && !entry)
        |=> $stable(pin_q));

    assert_shot_high_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (entry && mode == OCM_SHOT_FALL) |=> pin_q);

    assert_delay_once_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_DELAY && done_q && !entry) |=> $stable(pin_q));

    assert_pwm_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (entry && is_pwm(mode)) |=> (pin_q == $past(duty_nz)));

    assert_fault_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_PWM_FLT && !entry && (flt_q || !fault_n)) |=> !pin_q);

endmodule

// File: rtl/oc_irq.sv
module oc_irq
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ocm_e mode,
    input  logic entry,
    input  logic pin_q,
    input  logic pin_d,
    input  logic fault_fall,
    output logic irq_q
);

    logic irq_d;

    always_comb begin
        irq_d = 1'b0;
        if (!entry) begin
            irq_d = edge_irq(mode, pin_q, pin_d)
                 || (mode == OCM_PWM_FLT && fault_fall);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_d;
    end

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_OFF) |=> !irq_q);

    assert_pwm_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_PWM) |=> !irq_q);

    assert_toggle_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_TOGGLE && !entry) |=> (irq_q == (pin_q != $past(pin_q))));

endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] tmr,
    input  logic          per_match,
    input  logic [2:0]    mode,
    input  logic          pri_we,
    input  logic [CW-1:0] pri_wdata,
    input  logic          sec_we,
    input  logic [CW-1:0] sec_wdata,
    input  logic          gpio_val,
    input  logic          fault_n,
    output logic          pin_out,
    output logic          irq
);

    ocm_e          mode_e;
    logic [CW-1:0] pri_q, sec_q;
    oc_evt_t       evt;
    logic          pin_q, pin_d, entry, fault_fall;

    assign mode_e = ocm_e'(mode);

    oc_cmp_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .tmr       (tmr),
        .per_match (per_match),
        .pri_we    (pri_we),
        .pri_wdata (pri_wdata),
        .sec_we    (sec_we),
        .sec_wdata (sec_wdata),
        .pri_q     (pri_q),
        .sec_q     (sec_q),
        .evt       (evt)
    );

    oc_wave u_wave (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .evt        (evt),
        .duty_nz    (pri_q != '0),
        .sec_nz     (sec_q != '0),
        .fault_n    (fault_n),
        .pin_q      (pin_q),
        .pin_d      (pin_d),
        .entry      (entry),
        .fault_fall (fault_fall)
    );

    oc_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .entry      (entry),
        .pin_q      (pin_q),
        .pin_d      (pin_d),
        .fault_fall (fault_fall),
        .irq_q      (irq)
    );

    assign pin_out = (mode_e == OCM_OFF) ? gpio_val : pin_q;

endmodule

// File: tb/sim_oc_unit.sv
module sim_oc_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tmr = 8'd0;
    logic [7:0] per_lim = 8'd20;
    logic       run = 1'b0;
    logic       per_match;
    logic [2:0] mode = 3'd0;
    logic       pri_we = 1'b0, sec_we = 1'b0;
    logic [7:0] pri_wdata = 8'd0, sec_wdata = 8'd0;
    logic       gpio_val = 1'b0;
    logic       fault_n = 1'b1;
    logic       pin_out, irq;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    chk_on = 1'b0;
    bit    ended = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    assign per_match = run && (tmr == per_lim);

    oc_unit #(.CW(8)) u0 (
        .clk(clk), .rst(rst), .tmr(tmr), .per_match(per_match), .mode(mode),
        .pri_we(pri_we), .pri_wdata(pri_wdata), .sec_we(sec_we), .sec_wdata(sec_wdata),
        .gpio_val(gpio_val), .fault_n(fault_n), .pin_out(pin_out), .irq(irq)
    );

    // timer: counts while run, wraps after the period strobe
    always @(posedge clk) begin
        #1;
        if (run) tmr = (tmr == per_lim) ? 8'd0 : tmr + 8'd1;
    end

    // behavioural reference, updated on each rising edge from the stable inputs
    int m_pri, m_sec, m_prev_mode;
    bit m_pin, m_irq, m_done, m_flt, m_fprev;

    always @(posedge clk) begin
        int  t, md, nx_pri;
        bit  nx_pin, nx_irq, nx_done, nx_flt, fell;
        t  = int'(tmr);
        md = int'(mode);
        if (rst) begin
            m_pri = 0; m_sec = 0; m_prev_mode = 0;
            m_pin = 0; m_irq = 0; m_done = 0; m_flt = 0; m_fprev = 1;
        end else begin
            nx_pin = m_pin; nx_done = m_done; nx_flt = m_flt; nx_irq = 0;
            fell = m_fprev && !fault_n;
            if (md != m_prev_mode) begin
                nx_done = 0; nx_flt = 0;
                if (md == 2) nx_pin = 1;
                else if (md == 6 || md == 7) nx_pin = (m_pri != 0);
                else if (md == 0 || md == 3) nx_pin = m_pin;
                else nx_pin = 0;
            end else begin
                if ((md == 1 || md == 2) && !m_done && t == m_pri) begin
                    nx_pin = !m_pin; nx_done = 1;
                    nx_irq = 1;
                end
                if (md == 3 && t == m_pri) begin
                    nx_pin = !m_pin; nx_irq = 1;
                end
                if (md == 4 || md == 5) begin
                    if (m_pin && t == m_sec) begin
                        nx_pin = 0; nx_irq = 1;
                        if (md == 4) nx_done = 1;
                    end else if (!m_pin && !m_done && t == m_pri) nx_pin = 1;
                end
                if (md == 6 || md == 7) begin
                    if (md == 7 && (m_flt || !fault_n)) begin
                        nx_pin = 0; nx_flt = 1;
                    end else if (per_match) nx_pin = (m_sec != 0);
                    else if (t == m_pri) nx_pin = 0;
                    if (md == 7 && fell) nx_irq = 1;
                end
            end
            nx_pri = m_pri;
            if ((md == 6 || md == 7) && per_match) nx_pri = m_sec;
            else if (pri_we) nx_pri = int'(pri_wdata);
            if (sec_we) m_sec = int'(sec_wdata);
            m_pri = nx_pri;
            m_pin = nx_pin; m_irq = nx_irq; m_done = nx_done; m_flt = nx_flt;
            m_fprev = fault_n;
            m_prev_mode = md;
        end
    end

    // compare on the falling edge, every cycle
    always @(negedge clk) begin
        bit exp_pin;
        if (chk_on && !ended) begin
            exp_pin = (mode == 3'd0) ? gpio_val : m_pin;
            checks++;
            if (pin_out !== exp_pin) begin
                fails++;
                $display("FAIL %s pin_out actual %b expected %b cycle %0d",
                         cur_req, pin_out, exp_pin, cycles);
            end
            checks++;
            if (irq !== m_irq) begin
                fails++;
                $display("FAIL %s irq actual %b expected %b cycle %0d",
                         cur_req, irq, m_irq, cycles);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired cycle %0d", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_pri(input logic [7:0] v);
        @(posedge clk); #1 pri_we = 1'b1; pri_wdata = v;
        @(posedge clk); #1 pri_we = 1'b0;
    endtask

    task automatic wr_sec(input logic [7:0] v);
        @(posedge clk); #1 sec_we = 1'b1; sec_wdata = v;
        @(posedge clk); #1 sec_we = 1'b0;
    endtask

    // stop timer, zero it, rewrite mode, restart
    task automatic new_mode(input logic [2:0] m);
        @(posedge clk); #1 run = 1'b0;
        @(posedge clk); #1 tmr = 8'd0; mode = m;
        step(2);
        run = 1'b1;
    endtask

    initial begin
        step(3);
        chk_on = 1'b1;
        cur_req = "R1";
        step(2);
        rst = 1'b0;
        step(2);

        cur_req = "R2 R11";
        gpio_val = 1'b1; step(3);
        gpio_val = 1'b0; step(2);
        gpio_val = 1'b1; step(1);

        cur_req = "R12";
        wr_pri(8'd5);
        wr_sec(8'd12);
        step(2);

        cur_req = "R3 R11";
        new_mode(3'd1); step(50);
        cur_req = "R4";
        new_mode(3'd2); step(50);
        cur_req = "R5";
        new_mode(3'd3); step(70);
        cur_req = "R6";
        new_mode(3'd4); step(50);
        cur_req = "R7";
        new_mode(3'd5); step(70);

        cur_req = "R2";
        new_mode(3'd0); gpio_val = 1'b0; step(5);

        cur_req = "R8";
        wr_pri(8'd0);
        new_mode(3'd6); step(5);
        cur_req = "R9";
        wr_sec(8'd7); step(45);
        wr_sec(8'd0); step(45);
        wr_sec(8'd15); step(30);
        cur_req = "R12";
        wait (tmr == 8'd19); #1;
        wr_pri(8'd3); step(25);

        cur_req = "R8";
        new_mode(3'd7); step(10);
        cur_req = "R10";
        fault_n = 1'b0; step(2);
        fault_n = 1'b1; step(50);
        new_mode(3'd6); step(5);
        new_mode(3'd7); step(30);
        fault_n = 1'b0; step(1);
        fault_n = 1'b1; step(10);

        cur_req = "R5";
        new_mode(3'd3); step(30);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule